// File: doc/BRIEF.md
# Banked Register Window Decoder

This block places a 16-byte register window at a base address on a 16-bit host bus. It reaches several banks of register storage through that window. The base address has two parts. The high part comes from a configuration page value and the middle part from three strap pins, so the window moves in 16-byte steps. Bytes 0 to 13 of the window are general registers. The bank-select register currently chosen decides which bank they belong to.

The word at byte offsets 14–15 is the bank-select register. It is the same register whatever bank is selected, so the host can always switch banks. Its low byte holds the bank number. Its high byte reads back as a fixed signature, and writes to it are dropped. A new selection applies from the next bus cycle on. Every register word can be accessed as a whole word or as either of its two bytes. Writing one byte never changes the other byte of the same word.

The host bus uses plain strobes rather than a valid/ready stream. A read returns data combinationally in the cycle its strobe is high. A write takes effect at the clock edge that closes its cycle. There is no back-pressure: every access completes in one cycle. Rd and wr are never asserted together.

Top module: `bank_window_decoder`

## Requirements
- R1: After reset the selected bank is 0, every general register in every bank reads 0x0000, and the bank-select word reads 0x3300.
- R2: The window is hit when addr[15:4] equals {cfg_page, strap}, which puts the base at cfg_page*128 + strap*16. A write outside the window changes nothing. A read outside the window returns 0x0000.
- R3: Byte offsets 14–15 (word index 7) read as the bank-select word in every bank: bits 15:8 hold the signature 0x33, bits 7:2 are zero and bits 1:0 hold the bank number.
- R4: A write to word index 7 with the low lane enabled loads wdata[1:0] as the bank number, and the very next access uses the new bank. A write that enables only the high lane of that word leaves the bank unchanged.
- R5: Word indices 0–6 reach the storage of the selected bank only. Each of the four banks keeps its own values.
- R6: The active lanes are the byte enables be[1:0] (bit 0 for data bits 7:0, bit 1 for data bits 15:8) when addr[0] is 0. When addr[0] is 1 only be[1] counts, so an odd address reaches just bits 15:8. A write changes only the bytes on active lanes.
- R7: During a read, the bytes on inactive lanes return zero. When rd is low, rdata is 0x0000.
- R8: A word write at an even offset with be=2'b11 updates both bytes in one cycle, and a word read returns both bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_page | input | 9 | High part of the window base (address bits 15:7) |
| strap | input | 3 | Strap pins giving address bits 6:4 of the base |
| addr | input | 16 | Host byte address |
| be | input | 2 | Byte enables, bit 1 for data bits 15:8 |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data, lane-aligned |
| rdata | output | 16 | Read data, lane-aligned, zero when idle |

## Verification
Several rules are checked by assertions on every cycle:
- The bank register loads only on a low-lane write to word 7 and otherwise holds its value.
- A bank's storage stays the same when it is not written.
- A byte lane that is masked keeps its bytes.
- At most one bank is write-enabled in any cycle.
- Read data is zero when idle or outside the window.
- The signature appears whenever the select word is read.

Some properties can only be shown by the bench's scenarios:
- Each bank keeps its own contents.
- A new selection applies to the access directly after it.
- Byte merges give the right values.
- The window follows the strap pins to a new base.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int DATA_W    = 16;
  localparam int LANES     = DATA_W / 8;
  localparam int WIN_BYTES = 16;
  localparam int OFF_W     = $clog2(WIN_BYTES);
  localparam int WORDS     = WIN_BYTES / LANES;
  localparam int WORD_W    = $clog2(WORDS);
  localparam int NREG      = WORDS - 1;
  localparam logic [WORD_W-1:0] SEL_WORD = WORD_W'(WORDS - 1);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;
  typedef logic [WORD_W-1:0] widx_t;
endpackage

// File: rtl/bwd_decode.sv
module bwd_decode
  import bwd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int STRAP_W = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-OFF_W-STRAP_W-1:0]  cfg_page,
  input  logic [STRAP_W-1:0]               strap,
  input  logic [ADDR_W-1:0]                addr,
  input  lane_t                            be,
  output logic                             hit,
  output widx_t                            word,
  output lane_t                            lanes,
  output logic                             is_sel
);
  always_comb begin
    hit    = (addr[ADDR_W-1:OFF_W] == {cfg_page, strap});
    word   = addr[OFF_W-1:1];
    lanes  = addr[0] ? (be & lane_t'(2'b10)) : be;
    is_sel = (word == SEL_WORD);
  end

  p_odd_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr[0] |-> !lanes[0]);
endmodule

// File: rtl/bwd_bank_select.sv
module bwd_bank_select
  import bwd_pkg::*;
#(
  parameter int BSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BSEL_W-1:0] new_bank,
  output logic [BSEL_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (!rst_n)    bank <= '0;
    else if (load) bank <= new_bank;
  end

  p_bank_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bank == $past(new_bank));
  p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank));
endmodule

// File: rtl/bwd_bank_regs.sv
module bwd_bank_regs
  import bwd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  widx_t word,
  input  lane_t lanes,
  input  word_t wdata,
  output word_t rdata
);
  logic [NREG-1:0][DATA_W-1:0] mem;
  logic [NREG*8-1:0] lo_view, hi_view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (we && (int'(word) < NREG)) begin
      for (int l = 0; l < LANES; l++)
        if (lanes[l]) mem[word][8*l +: 8] <= wdata[8*l +: 8];
    end
  end

  always_comb rdata = (int'(word) < NREG) ? mem[word] : '0;

  for (genvar w = 0; w < NREG; w++) begin : g_view
    assign lo_view[8*w +: 8] = mem[w][7:0];
    assign hi_view[8*w +: 8] = mem[w][15:8];
  end

  p_store_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));
  p_keep_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !lanes[1]) |=> $stable(hi_view));
  p_keep_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !lanes[0]) |=> $stable(lo_view));
endmodule

// File: rtl/bank_window_decoder.sv
module bank_window_decoder
  import bwd_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         STRAP_W = 3,
  parameter int         NBANK   = 4,
  parameter logic [7:0] SIG     = 8'h33
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-OFF_W-STRAP_W-1:0] cfg_page,
  input  logic [STRAP_W-1:0]              strap,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [1:0]                      be,
  input  logic                            rd,
  input  logic                            wr,
  input  logic [15:0]                     wdata,
  output logic [15:0]                     rdata
);
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic              hit, is_sel;
  widx_t             word;
  lane_t             lanes;
  logic [BSEL_W-1:0] bank;
  logic              sel_load;
  logic [NBANK-1:0]  bank_we;
  word_t             bank_rd [NBANK];
  word_t             sel_word, raw_rd;

  bwd_decode #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cfg_page(cfg_page), .strap(strap),
    .addr(addr), .be(be), .hit(hit), .word(word), .lanes(lanes),
    .is_sel(is_sel)
  );

  assign sel_load = wr && hit && is_sel && lanes[0];

  bwd_bank_select #(.BSEL_W(BSEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .load(sel_load),
    .new_bank(wdata[BSEL_W-1:0]), .bank(bank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_we[b] = wr && hit && !is_sel && (int'(bank) == b);
    bwd_bank_regs u_regs (
      .clk(clk), .rst_n(rst_n), .we(bank_we[b]), .word(word),
      .lanes(lanes), .wdata(wdata), .rdata(bank_rd[b])
    );
  end

  always_comb begin
    sel_word = {SIG, 8'(bank)};
    raw_rd   = is_sel ? sel_word : bank_rd[bank];
    rdata    = '0;
    if (rd && hit)
      for (int l = 0; l < LANES; l++)
        if (lanes[l]) rdata[8*l +: 8] = raw_rd[8*l +: 8];
  end

  p_one_bank_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> rdata == 16'h0000);
  p_outside_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |-> rdata == 16'h0000);
  p_sig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit && is_sel && lanes[1]) |-> rdata[15:8] == SIG);
endmodule

// File: tb/bank_window_decoder_test.sv
module bank_window_decoder_test;
  logic        clk = 0, rst_n = 0;
  logic [8:0]  cfg_page = 9'h005;
  logic [2:0]  strap = 3'd2;
  logic [15:0] addr = '0, wdata = '0, rdata;
  logic [1:0]  be = '0;
  logic        rd = 0, wr = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  localparam logic [15:0] BASE = 16'h02A0;

  bank_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_page(cfg_page), .strap(strap),
    .addr(addr), .be(be), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr = 1; rd = 0;
    @(negedge clk);
    wr = 0; be = 0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] b, output logic [15:0] d);
    @(negedge clk);
    addr = a; be = b; rd = 1; wr = 0;
    #2 d = rdata;
    @(negedge clk);
    rd = 0; be = 0;
  endtask

  task automatic read_chk(input string req, input logic [15:0] a, input logic [1:0] b, input logic [15:0] exp);
    logic [15:0] d;
    do_read(a, b, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    read_chk("R1 sel word", BASE + 16'd14, 2'b11, 16'h3300);
    read_chk("R1 reg0", BASE, 2'b11, 16'h0000);
    read_chk("R1 reg12", BASE + 16'd12, 2'b11, 16'h0000);
  endtask

  task automatic t_banks;
    for (int b = 0; b < 4; b++) begin
      do_write(BASE + 16'd14, 2'b01, 16'(b));
      do_write(BASE, 2'b11, 16'h1000 + 16'(b) * 16'h0111);
      do_write(BASE + 16'd12, 2'b11, 16'hC000 + 16'(b));
    end
    for (int b = 0; b < 4; b++) begin
      do_write(BASE + 16'd14, 2'b01, 16'(b));
      read_chk("R5 bank reg0", BASE, 2'b11, 16'h1000 + 16'(b) * 16'h0111);
      read_chk("R5 bank reg12", BASE + 16'd12, 2'b11, 16'hC000 + 16'(b));
      read_chk("R3 sel readback", BASE + 16'd14, 2'b11, 16'h3300 | 16'(b));
    end
  endtask

  task automatic t_next;
    do_write(BASE + 16'd14, 2'b01, 16'h0002);
    read_chk("R4 next access bank2", BASE, 2'b11, 16'h1222);
    do_write(BASE + 16'd14, 2'b01, 16'h0001);
    read_chk("R4 next access bank1", BASE, 2'b11, 16'h1111);
  endtask

  task automatic t_sel_hi;
    do_write(BASE + 16'd15, 2'b10, 16'hFF03);
    read_chk("R4 odd sel write ignored", BASE + 16'd14, 2'b11, 16'h3301);
    do_write(BASE + 16'd14, 2'b10, 16'h5502);
    read_chk("R4 high lane sel write ignored", BASE + 16'd14, 2'b11, 16'h3301);
  endtask

  task automatic t_bytes;
    do_write(BASE + 16'd14, 2'b01, 16'h0003);
    do_write(BASE + 16'd4, 2'b11, 16'h1234);
    read_chk("R8 word write", BASE + 16'd4, 2'b11, 16'h1234);
    do_write(BASE + 16'd5, 2'b10, 16'hAB00);
    read_chk("R6 odd byte write", BASE + 16'd4, 2'b11, 16'hAB34);
    do_write(BASE + 16'd4, 2'b01, 16'h00CD);
    read_chk("R6 even byte write", BASE + 16'd4, 2'b11, 16'hABCD);
    do_write(BASE + 16'd5, 2'b01, 16'h00EE);
    read_chk("R6 odd addr masks low lane", BASE + 16'd4, 2'b11, 16'hABCD);
  endtask

  task automatic t_lanes;
    read_chk("R7 odd read high only", BASE + 16'd5, 2'b11, 16'hAB00);
    read_chk("R7 low lane read", BASE + 16'd4, 2'b01, 16'h00CD);
    @(negedge clk);
    addr = BASE + 16'd4; be = 2'b11; rd = 0;
    #2 check("R7 idle rdata", rdata, 16'h0000);
    @(negedge clk);
    be = 0;
  endtask

  task automatic t_window;
    do_write(16'h03A0, 2'b11, 16'hDEAD);
    read_chk("R2 outside write ignored", BASE, 2'b11, 16'h1333);
    read_chk("R2 outside read zero", 16'h03A0, 2'b11, 16'h0000);
    do_write(16'h03AE, 2'b01, 16'h0000);
    read_chk("R2 outside sel write ignored", BASE + 16'd14, 2'b11, 16'h3303);
    @(negedge clk);
    strap = 3'd3;
    read_chk("R2 moved window sel", 16'h02BE, 2'b11, 16'h3303);
    read_chk("R2 moved window reg0", 16'h02B0, 2'b11, 16'h1333);
    read_chk("R2 old base now outside", 16'h02A0, 2'b11, 16'h0000);
    strap = 3'd2;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_banks();
    t_next();
    t_sel_hi();
    t_bytes();
    t_lanes();
    t_window();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule